// File: doc/BRIEF.md
# Integer ALU with Flag Register and Condition Evaluator

This block is the arithmetic core of a small load/store processor. A combinational datapath takes two operands and a two-bit function code. It produces an addition, a subtraction, a bitwise AND or a bitwise XOR. Three status flags (zero, sign and signed overflow) sit in a register beside the datapath. The register loads on the rising clock edge only while the update enable is high. The processor raises that enable for arithmetic and logic instructions. It leaves it low when the same adder serves address or stack-pointer arithmetic.

A condition evaluator reads only the stored flags and a three-bit condition code. It returns one bit that says whether the condition holds. Conditional jumps and conditional register moves both use this same bit, so the two instruction kinds always agree on what each condition means. There is no carry flag. Every comparison condition is a signed one.

Top module: `alu_cc`

## Requirements
- R1: With function code 0 the result is op_b + op_a modulo 2^W.
- R2: With function code 1 the result is op_b - op_a modulo 2^W, so op_b is the minuend.
- R3: Function code 2 gives op_a AND op_b. Function code 3 gives op_a XOR op_b. XOR of two equal operands yields zero, and an update in that cycle sets the zero flag.
- R4: On a rising edge with set_cc high and rst low, the flags load the current result. zf = (result == 0) and sf = the top bit of result. For add and subtract, of is set exactly when the true signed result lies outside the W-bit signed range. For AND and XOR, of is cleared.
- R5: On a rising edge with set_cc low and rst low, zf, sf and of keep their values whatever the other inputs do.
- R6: On a rising edge with rst high, all three flags clear to 0. This holds even when set_cc is high.
- R7: cond_true depends only on the stored flags and cond_fn. Code 0 always gives 1. Code 1 (le) gives (sf^of)|zf. Code 2 (l) gives sf^of. Code 3 (e) gives zf. Code 4 (ne) gives ~zf. Code 5 (ge) gives ~(sf^of). Code 6 (g) gives ~(sf^of)&~zf.
- R8: The unused condition code 7 always gives cond_true = 0.
- R9: Within a cycle in which the flags are being updated, cond_true is computed from the flags held before that edge. The new flags affect cond_true only after the edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; flags load on the rising edge |
| rst | input | 1 | Synchronous reset of the flag register, active high |
| fn | input | 2 | ALU function: 0 add, 1 subtract, 2 AND, 3 XOR |
| op_a | input | W | First operand (subtrahend for subtract) |
| op_b | input | W | Second operand (minuend for subtract) |
| set_cc | input | 1 | Flag update enable for this cycle |
| cond_fn | input | 3 | Condition code, 0 always through 6 greater |
| result | output | W | Combinational ALU result |
| zf | output | 1 | Stored zero flag |
| sf | output | 1 | Stored sign flag |
| of | output | 1 | Stored overflow flag |
| cond_true | output | 1 | Evaluated condition on the stored flags |

## Verification
A flag update and a condition evaluation fall in the same cycle whenever set_cc is high and cond_fn selects a comparison. The case matters most when the operation would flip the answer, for example an equal-operand subtract while the stored flags say "not equal". The bench provokes this with directed sequences and with random cycles that keep set_cc and cond_fn active together. In each cycle it checks cond_true before the edge against a model that holds the old flags. After the edge it checks the flag outputs against the new values the model computes from the operands.

// File: rtl/alu_cc.sv
module alu_cc #(
  parameter int W = 64
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [1:0]   fn,
  input  logic [W-1:0] op_a,
  input  logic [W-1:0] op_b,
  input  logic         set_cc,
  input  logic [2:0]   cond_fn,
  output logic [W-1:0] result,
  output logic         zf,
  output logic         sf,
  output logic         of,
  output logic         cond_true
);

  localparam int MSB = W - 1;

  logic         is_sub;
  logic [W-1:0] add_y;
  logic [W-1:0] sum;
  logic         arith_ovf;
  logic         lt;

  assign is_sub    = (fn == 2'd1);
  assign add_y     = is_sub ? ~op_a : op_a;
  assign sum       = op_b + add_y + {{(W-1){1'b0}}, is_sub};
  assign arith_ovf = (op_b[MSB] == add_y[MSB]) && (sum[MSB] != op_b[MSB]);

  always_comb begin
    case (fn)
      2'd2:    result = op_a & op_b;
      2'd3:    result = op_a ^ op_b;
      default: result = sum;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      zf <= 1'b0;
      sf <= 1'b0;
      of <= 1'b0;
    end else if (set_cc) begin
      zf <= (result == '0);
      sf <= result[MSB];
      of <= fn[1] ? 1'b0 : arith_ovf;
    end
  end

  assign lt = sf ^ of;

  always_comb begin
    case (cond_fn)
      3'd0:    cond_true = 1'b1;
      3'd1:    cond_true = lt | zf;
      3'd2:    cond_true = lt;
      3'd3:    cond_true = zf;
      3'd4:    cond_true = ~zf;
      3'd5:    cond_true = ~lt;
      3'd6:    cond_true = ~lt & ~zf;
      default: cond_true = 1'b0;
    endcase
  end

endmodule

module alu_cc_chk #(
  parameter int W = 64
) (
  input logic         clk,
  input logic         rst,
  input logic [1:0]   fn,
  input logic [W-1:0] op_a,
  input logic [W-1:0] op_b,
  input logic         set_cc,
  input logic [2:0]   cond_fn,
  input logic [W-1:0] result,
  input logic         zf,
  input logic         sf,
  input logic         of,
  input logic         cond_true
);

  AST_FLAG_HOLD: assert property (@(posedge clk) disable iff (rst)
    !set_cc |=> $stable({zf, sf, of})); // R5
  AST_ZF_LOAD: assert property (@(posedge clk) disable iff (rst)
    set_cc |=> zf == ($past(result) == '0)); // R4
  AST_SF_LOAD: assert property (@(posedge clk) disable iff (rst)
    set_cc |=> sf == $past(result[W-1])); // R4
  AST_LOGIC_NO_OF: assert property (@(posedge clk) disable iff (rst)
    (set_cc && fn[1]) |=> !of); // R4
  AST_RESET_CLEAR: assert property (@(posedge clk)
    rst |=> (!zf && !sf && !of)); // R6
  AST_XOR_SELF: assert property (@(posedge clk) disable iff (rst)
    (fn == 2'd3 && op_a == op_b) |-> result == '0); // R3
  AST_EQ_COND: assert property (@(posedge clk) disable iff (rst)
    (cond_fn == 3'd3) |-> cond_true == zf); // R7
  AST_UNUSED_COND: assert property (@(posedge clk) disable iff (rst)
    (cond_fn == 3'd7) |-> !cond_true); // R8

endmodule

bind alu_cc alu_cc_chk #(.W(W)) u_alu_cc_chk (.*);

// File: tb/alu_cc_bench.sv
`timescale 1ns/1ps
module alu_cc_bench;
  localparam int W = 64;

  logic         clk = 1'b0;
  logic         rst;
  logic [1:0]   fn;
  logic [W-1:0] op_a, op_b;
  logic         set_cc;
  logic [2:0]   cond_fn;
  logic [W-1:0] result;
  logic         zf, sf, of, cond_true;

  int checks = 0;
  int failures = 0;
  logic mzf = 1'b0, msf = 1'b0, mof = 1'b0;

  always #2.5 clk = ~clk;

  alu_cc #(.W(W)) u_alu_cc (
    .clk(clk), .rst(rst), .fn(fn), .op_a(op_a), .op_b(op_b),
    .set_cc(set_cc), .cond_fn(cond_fn), .result(result),
    .zf(zf), .sf(sf), .of(of), .cond_true(cond_true)
  );

  function automatic logic [W-1:0] exp_res(input logic [1:0] f, input logic [W-1:0] a, input logic [W-1:0] b);
    case (f)
      2'd0: return b + a;
      2'd1: return b - a;
      2'd2: return a & b;
      default: return a ^ b;
    endcase
  endfunction

  function automatic logic exp_ovf(input logic [1:0] f, input logic [W-1:0] a, input logic [W-1:0] b);
    logic [W:0] wide;
    if (f[1]) return 1'b0;
    if (f == 2'd0) wide = {b[W-1], b} + {a[W-1], a};
    else           wide = {b[W-1], b} - {a[W-1], a};
    return wide[W] != wide[W-1];
  endfunction

  function automatic logic exp_cond(input logic [2:0] c, input logic z, input logic s, input logic o);
    case (c)
      3'd0: return 1'b1;
      3'd1: return (s != o) || z;
      3'd2: return s != o;
      3'd3: return z;
      3'd4: return !z;
      3'd5: return s == o;
      3'd6: return (s == o) && !z;
      default: return 1'b0;
    endcase
  endfunction

  task automatic chk(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic step(input logic [1:0] f, input logic [W-1:0] a, input logic [W-1:0] b,
                      input logic s, input logic [2:0] c, input logic r);
    logic [W-1:0] er;
    @(negedge clk);
    fn = f; op_a = a; op_b = b; set_cc = s; cond_fn = c; rst = r;
    #1;
    er = exp_res(f, a, b);
    if (!r) begin
      case (f)
        2'd0: chk("R1 add result", result, er);
        2'd1: chk("R2 sub result", result, er);
        default: chk("R3 logic result", result, er);
      endcase
      if (c == 3'd7) chk("R8 unused cond", {63'd0, cond_true}, 64'd0);
      else if (s) chk("R9 cond uses old flags", {63'd0, cond_true}, {63'd0, exp_cond(c, mzf, msf, mof)});
      else chk("R7 cond eval", {63'd0, cond_true}, {63'd0, exp_cond(c, mzf, msf, mof)});
    end
    @(posedge clk);
    if (r) begin
      mzf = 1'b0; msf = 1'b0; mof = 1'b0;
    end else if (s) begin
      mzf = (er == '0); msf = er[W-1]; mof = exp_ovf(f, a, b);
    end
    #1;
    if (r) chk("R6 reset flags", {61'd0, zf, sf, of}, {61'd0, mzf, msf, mof});
    else if (s) chk("R4 flag load", {61'd0, zf, sf, of}, {61'd0, mzf, msf, mof});
    else chk("R5 flag hold", {61'd0, zf, sf, of}, {61'd0, mzf, msf, mof});
  endtask

  localparam logic [W-1:0] MAXP = {1'b0, {(W-1){1'b1}}};
  localparam logic [W-1:0] MINN = {1'b1, {(W-1){1'b0}}};

  initial begin
    #(5.0 * 190000);
    failures++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    rst = 1'b1; fn = 2'd0; op_a = '0; op_b = '0; set_cc = 1'b0; cond_fn = 3'd0;
    step(2'd0, 0, 0, 1'b1, 3'd0, 1'b1);
    step(2'd0, 0, 0, 1'b0, 3'd0, 1'b1);
    // R3: xor self gives zero and sets ZF
    step(2'd3, 64'hDEAD_BEEF_0123_4567, 64'hDEAD_BEEF_0123_4567, 1'b1, 3'd4, 1'b0);
    for (int c = 0; c < 8; c++) step(2'd0, 1, 2, 1'b0, c[2:0], 1'b0);
    // R1 R4: positive overflow on add
    step(2'd0, 1, MAXP, 1'b1, 3'd3, 1'b0);
    for (int c = 0; c < 8; c++) step(2'd2, '1, 5, 1'b0, c[2:0], 1'b0);
    // R2 R4: negative overflow on sub (MINN - 1)
    step(2'd1, 1, MINN, 1'b1, 3'd2, 1'b0);
    // R2: sub of MINN from nonneg overflows
    step(2'd1, MINN, 0, 1'b1, 3'd5, 1'b0);
    // R4: AND clears overflow
    step(2'd2, '1, MINN, 1'b1, 3'd1, 1'b0);
    for (int c = 0; c < 8; c++) step(2'd3, 7, 9, 1'b0, c[2:0], 1'b0);
    // R9: equal compare while old flags say not-equal
    step(2'd1, 3, 4, 1'b1, 3'd0, 1'b0);
    step(2'd1, 42, 42, 1'b1, 3'd3, 1'b0);
    step(2'd1, 42, 42, 1'b1, 3'd4, 1'b0);
    // R5: operands that would flip flags, no update
    step(2'd1, 5, 1, 1'b0, 3'd3, 1'b0);
    // R6: reset beats set_cc
    step(2'd1, 5, 1, 1'b1, 3'd0, 1'b1);
    for (int i = 0; i < 600; i++) begin
      logic [W-1:0] a, b;
      a = {$urandom(), $urandom()};
      b = ($urandom_range(0, 5) == 0) ? a : {$urandom(), $urandom()};
      if ($urandom_range(0, 7) == 0) a = {a[W-1], {(W-1){~a[W-1]}}};
      step($urandom_range(0, 3), a, b, $urandom_range(0, 2) != 0,
           $urandom_range(0, 7), $urandom_range(0, 60) == 0);
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule